// File: doc/BRIEF.md
# Divide-by-2.5 Clock Generator

The block takes a fast reference clock and derives an output clock at two fifths of its frequency. For example, a 50 MHz reference gives 20 MHz and a 100 MHz reference gives 40 MHz.

It reaches the half-integer ratio by using both edges of the reference:

- A five-state sequence advances once per reference cycle.
- One register bank is clocked on the rising edge and a second bank on the falling edge.
- Each output is the OR of one register from each bank. Every output transition is therefore launched directly by a reference edge, and no combinational race can create a pulse.

A companion output runs at one fifth of the reference with an even duty cycle.

Reset takes effect at once when it is asserted. Its release is passed through a short synchronizer on the rising edge, so both banks always restart from the same phase. The divided waveforms carry any asymmetry of the reference duty cycle: consecutive periods of the 2.5 output alternate in length, and their sum is always five reference periods.

Top module: `half_ratio_clkdiv`

## Requirements
- R1: The 2.5 output (`clkOut25`) repeats every 5 reference half-periods, and its rising edges alternate between reference rising and reference falling edges.
- R2: Within each 5-half-period cycle, `clkOut25` is high for exactly 2 half-periods and low for 3.
- R3: `clkOut5` is high for 5 half-periods and then low for 5. It rises on the same reference rising edge as every second rise of `clkOut25`.
- R4: While `rst` is high, both outputs are low. A reset asserted in mid-cycle forces them low without waiting for a clock edge and clears the phase sequence.
- R5: After `rst` falls, both outputs first rise on the third reference rising edge. The pattern then follows R1 to R3 from that edge on.
- R6: With an asymmetric reference (high time H, low time L), the period of `clkOut25` ending on a reference rising edge is 2H+3L. The period ending on a falling edge is 3H+2L.
- R7: Both outputs are free of glitches. The rising-edge and falling-edge half-waveforms that form `clkOut25` are never high at the same time, and every output edge is spaced a whole number of reference half-periods from the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Reference clock; both edges are used |
| rst | input | 1 | Active-high reset; asserted asynchronously, released on a rising edge |
| clkOut25 | output | 1 | Reference divided by 2.5, 40/60 duty |
| clkOut5 | output | 1 | Reference divided by 5, 50/50 duty |

## Verification
A sequence state that is wrong or skipped shows within one output period, at most 10 reference half-periods. It appears as a high or low run of the wrong length, or as a period that does not match the reference duty cycle.

A falling-edge register that loses phase against the rising-edge bank shows as an overlap, or as a pulse that is short by one half-period, on the very next `clkOut25` pulse. A fault in the reset synchronizer moves the first rising edge away from the third reference rising edge after release, so it is seen within a handful of edges after every reset.

// File: rtl/div25_pkg.sv
`timescale 1ns/1ps
package div25_pkg;
  // Reference cycles per repeat of the phase sequence (two 2.5 periods).
  localparam int unsigned SEQ_LEN = 5;
  localparam int unsigned CNT_W   = $clog2(SEQ_LEN);
  // Slot in which the rising-edge half of the 2.5 pulse is launched.
  localparam int unsigned PULSE_SLOT = 0;
  // Slot whose falling edge launches the second 2.5 pulse.
  localparam int unsigned MID_SLOT = (SEQ_LEN - 1) / 2;
  // Last slot of the rising-edge part of the divide-by-5 high phase.
  localparam int unsigned SPAN_LAST = MID_SLOT - 1;

  typedef struct packed {
    logic firstPair;  // rising-edge half of the 2.5 pulse
    logic lowSpan;    // rising-edge part of the divide-by-5 high phase
    logic midPoint;   // arms the falling-edge half of the 2.5 pulse
  } phaseStrobes_t;
endpackage

// File: rtl/div25_ctrl.sv
`timescale 1ns/1ps
module div25_ctrl
  import div25_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clkIn,
  input  logic             rst,
  output logic [CNT_W-1:0] seqCount,
  output phaseStrobes_t    strb
);
  localparam logic [CNT_W-1:0] LAST_STATE = CNT_W'(SEQ_LEN - 1);
  localparam logic [CNT_W-1:0] PULSE_ST   = CNT_W'(PULSE_SLOT);
  localparam logic [CNT_W-1:0] MID_ST     = CNT_W'(MID_SLOT);
  localparam logic [CNT_W-1:0] SPAN_ST    = CNT_W'(SPAN_LAST);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   runEn;

  // Assert at once, release through a rising-edge synchronizer chain.
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clkIn or posedge rst) begin
        if (rst) syncQ <= '0;
        else     syncQ <= 1'b1;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clkIn or posedge rst) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign runEn = syncQ[SYNC_STAGES-1];

  // Phase sequence and registered decodes, all on the rising edge.
  always_ff @(posedge clkIn or posedge rst) begin
    if (rst) begin
      seqCount <= '0;
      strb     <= '0;
    end else if (runEn) begin
      seqCount       <= (seqCount == LAST_STATE) ? '0 : seqCount + 1'b1;
      strb.firstPair <= (seqCount == PULSE_ST);
      strb.lowSpan   <= (seqCount <= SPAN_ST);
      strb.midPoint  <= (seqCount == MID_ST);
    end
  end
endmodule

// File: rtl/div25_dp.sv
`timescale 1ns/1ps
module div25_dp
  import div25_pkg::*;
(
  input  logic          clkIn,
  input  logic          rst,
  input  phaseStrobes_t strb,
  output logic          lateHalf,
  output logic          clkOut25,
  output logic          clkOut5
);
  logic lateTail;

  // Falling-edge bank: each register follows a rising-edge strobe half a cycle later.
  always_ff @(negedge clkIn or posedge rst) begin
    if (rst) begin
      lateHalf <= 1'b0;
      lateTail <= 1'b0;
    end else begin
      lateHalf <= strb.midPoint;
      lateTail <= strb.lowSpan;
    end
  end

  // OR of registers only; the two inputs never move in opposite directions at once.
  assign clkOut25 = strb.firstPair | lateHalf;
  assign clkOut5  = strb.lowSpan | lateTail;
endmodule

// File: rtl/half_ratio_clkdiv.sv
`timescale 1ns/1ps
module half_ratio_clkdiv
  import div25_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clkIn,
  input  logic rst,
  output logic clkOut25,
  output logic clkOut5
);
  logic [CNT_W-1:0] seqCount;
  phaseStrobes_t    strb;
  logic             lateHalf;

  div25_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clkIn    (clkIn),
    .rst      (rst),
    .seqCount (seqCount),
    .strb     (strb)
  );

  div25_dp uDp (
    .clkIn    (clkIn),
    .rst      (rst),
    .strb     (strb),
    .lateHalf (lateHalf),
    .clkOut25 (clkOut25),
    .clkOut5  (clkOut5)
  );
endmodule

// File: rtl/div25_chk.sv
`timescale 1ns/1ps
module div25_chk
  import div25_pkg::*;
(
  input logic             clkIn,
  input logic             rst,
  input logic             clkOut25,
  input logic             clkOut5,
  input logic [CNT_W-1:0] seqCount,
  input phaseStrobes_t    strb,
  input logic             lateHalf
);
  // R1
  seq_range_chk: assert property (@(posedge clkIn) disable iff (rst)
    32'(seqCount) < SEQ_LEN);

  // R1
  seq_wrap_chk: assert property (@(posedge clkIn) disable iff (rst)
    (32'(seqCount) == SEQ_LEN - 1) |=> (seqCount == '0));

  // R2
  pulse_gap_chk: assert property (@(posedge clkIn) disable iff (rst)
    clkOut25 |=> !clkOut25);

  // R3
  div5_high_chk: assert property (@(posedge clkIn) disable iff (rst)
    $rose(clkOut5) |=> clkOut5);

  // R3
  div5_low_chk: assert property (@(posedge clkIn) disable iff (rst)
    $fell(clkOut5) |=> !clkOut5 ##1 !clkOut5);

  // R4
  reset_low_chk: assert property (@(posedge clkIn)
    (rst && $past(rst)) |-> (!clkOut25 && !clkOut5));

  // R7
  halves_rise_chk: assert property (@(posedge clkIn) disable iff (rst)
    !(strb.firstPair && lateHalf));

  // R7
  halves_fall_chk: assert property (@(negedge clkIn) disable iff (rst)
    !(strb.firstPair && lateHalf));
endmodule

bind half_ratio_clkdiv div25_chk u_div25_chk (
  .clkIn    (clkIn),
  .rst      (rst),
  .clkOut25 (clkOut25),
  .clkOut5  (clkOut5),
  .seqCount (seqCount),
  .strb     (strb),
  .lateHalf (lateHalf)
);

// File: tb/half_ratio_clkdiv_bench.sv
`timescale 1ns/1ps
module half_ratio_clkdiv_bench;
  logic clkIn = 1'b0;
  logic rst   = 1'b1;
  wire  out25;
  wire  out5;

  half_ratio_clkdiv u_half_ratio_clkdiv (
    .clkIn    (clkIn),
    .rst      (rst),
    .clkOut25 (out25),
    .clkOut5  (out5)
  );

  int     checks   = 0;
  int     bad      = 0;
  int     hiNs     = 10;   // 50 MHz default: 10 ns high, 10 ns low
  int     loNs     = 10;
  int     k        = -1;   // half-period index since the first running edge
  int     relEdges = -1;   // rising edges since reset release
  bit     lvl      = 1'b0;
  bit     relReq   = 1'b0;
  bit     rstReq   = 1'b0;
  bit     done     = 1'b0;
  longint lastRise25 = -1;
  longint lastRise5  = -1;

  function automatic bit exp25(int idx);
    return (idx >= 0) && ((idx % 5) < 2);
  endfunction

  function automatic bit exp5(int idx);
    return (idx >= 0) && ((idx % 10) < 5);
  endfunction

  function automatic longint expPeriod25(bit endsOnRise, int h, int l);
    return endsOnRise ? longint'(2 * h + 3 * l) : longint'(3 * h + 2 * l);
  endfunction

  task automatic chkBit(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, expv);
    end
  endtask

  task automatic chkNum(string req, longint act, longint expv);
    checks++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, expv);
    end
  endtask

  // One reference half-period, with a sample taken in its middle.
  task automatic tick();
    int d;
    int restNs;
    lvl = !lvl;
    d = lvl ? hiNs : loNs;
    clkIn = lvl;
    if (k >= 0) k++;
    if (lvl && relEdges >= 0) begin
      relEdges++;
      if (relEdges == 3) k = 0;
    end
    #(d / 2);
    restNs = d - d / 2;
    if (rstReq) begin
      rst = 1'b1;
      rstReq = 1'b0;
      relEdges = -1;
      k = -1;
      lastRise25 = -1;
      lastRise5 = -1;
      #1;
      restNs = restNs - 1;
      chkBit("R4 async clear clkOut25", out25, 1'b0);
      chkBit("R4 async clear clkOut5", out5, 1'b0);
    end else if (rst) begin
      chkBit("R4 held clkOut25", out25, 1'b0);
      chkBit("R4 held clkOut5", out5, 1'b0);
    end else if (k < 0) begin
      chkBit("R5 wait clkOut25", out25, 1'b0);
      chkBit("R5 wait clkOut5", out5, 1'b0);
    end else begin
      chkBit("R2 clkOut25 level", out25, exp25(k));
      chkBit("R3 clkOut5 level", out5, exp5(k));
    end
    if (relReq && !lvl) begin
      rst = 1'b0;
      relReq = 1'b0;
      relEdges = 0;
    end
    #(restNs);
  endtask

  // Period of clkOut25 (R1, R6); also the first-rise position (R5), and
  // spacing under glitches (R7).
  always @(posedge out25) begin
    if (!rst) begin
      if (lastRise25 < 0) begin
        chkNum("R5 first rise edge count", relEdges, 3);
        chkNum("R5 first rise on rising edge", clkIn, 1);
      end else begin
        chkNum("R6 clkOut25 period ns", $time - lastRise25,
               expPeriod25(clkIn, hiNs, loNs));
      end
      lastRise25 = $time;
    end
  end

  // R3: the divide-by-5 period is always five whole reference cycles.
  always @(posedge out5) begin
    if (!rst) begin
      if (lastRise5 >= 0)
        chkNum("R3 clkOut5 period ns", $time - lastRise5, longint'(5 * (hiNs + loNs)));
      else
        chkBit("R3 clkOut5 rises with clkOut25", out25, 1'b1);
      lastRise5 = $time;
    end
  end

  task automatic runSegment(int h, int l, int holdHalves, int runHalves);
    hiNs = h;
    loNs = l;
    for (int i = 0; i < holdHalves; i++) tick();
    while (lvl != 1'b1) tick();
    relReq = 1'b1;
    tick();
    for (int i = 0; i < runHalves; i++) tick();
    rstReq = 1'b1;          // R4: reset arrives in mid-cycle
    tick();
  endtask

  initial begin
    int h;
    void'($urandom(32'd2718));
    // R4: reset state before any release
    for (int i = 0; i < 6; i++) tick();
    // R1 R2 R3 symmetric 50 MHz reference
    runSegment(10, 10, 4, 120);
    // R6 directed 40/60 reference: periods alternate
    runSegment(8, 12, 5, 120);
    // R6 directed 70/30 reference
    runSegment(14, 6, 4, 100);
    // R5 restart after a short run cut before the first full cycle
    runSegment(10, 10, 4, 7);
    // Random duty cycles and random hold lengths
    for (int s = 0; s < 4; s++) begin
      h = 6 + int'($urandom % 9);
      runSegment(h, 20 - h, 4 + int'($urandom % 4), 60 + int'($urandom % 60));
    end
    for (int i = 0; i < 4; i++) tick();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule